// File: doc/BRIEF.md
# Masked Block Write-Transfer Buffer

This block collects an eight-word block of 16-bit data in a first-stage write buffer, one word per command, and then moves the whole block in a single transfer command into one of 32 block slots of a modelled memory row. A byte-lane mask register decides which bytes of the target slot the transfer overwrites. A blocked byte keeps its old contents. The mask is loaded from the data bus by a command of its own. A second transfer variant also copies the resulting slot contents into a read buffer. During a transfer a second-stage buffer captures the first stage, and it also captures the per-word byte-enable bits recorded at buffer-write time. Those per-word bits take no part in deciding which bytes are written.

Commands arrive on a valid/ready interface. `cmd_ready` is held high, so every beat with `cmd_valid` high is accepted in the cycle it is presented, and the block never applies back-pressure. Each accepted command finishes in one clock. Its effect can be seen on the combinational read ports from the next cycle onward. A transfer whose guard address bits are not zero is dropped and sets a sticky error flag.

Top module: `blk_xfer_buf`

## Requirements
- R1: After reset every row word, every read-buffer word, every first-stage word and the mask register read zero, `xfer_err` is low, and `cmd_ready` is high.
- R2: A buffer-write command (op 1) stores `cmd_data` into first-stage word `cmd_addr[2:0]` and leaves the other seven words unchanged.
- R3: A load-mask command (op 2) sets mask bit i to `cmd_data[i]`. Bit 2w covers the lower byte (bits 7:0) of word w, and bit 2w+1 covers its upper byte. A set bit protects that byte. No other command changes the mask.
- R4: A transfer command (op 3) with `cmd_addr[9:8]` zero writes the first-stage block into slot `cmd_addr[7:3]`, replacing only the unprotected bytes. The new contents are readable on the next cycle, and all other slots are unchanged.
- R5: A transfer-and-read command (op 4) performs the R4 write and in the same clock loads the read buffer with the slot contents as they stand after that write.
- R6: The read buffer changes only on an accepted op 4. A plain transfer leaves it unchanged.
- R7: A transfer (op 3 or 4) with `cmd_addr[8]` or `cmd_addr[9]` high changes no row slot and no read-buffer word. It raises `xfer_err` on the next cycle, and `xfer_err` then stays high until reset.
- R8: The per-word byte enables `cmd_bmask` given with a buffer write have no effect on which bytes a transfer writes.
- R9: The first-stage buffer and the mask keep their contents across transfers, so the same block can be written to several slots.
- R10: Ops 0, 5, 6 and 7, and any cycle with `cmd_valid` low, change no row, read-buffer, mask or error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command beat present |
| cmd_ready | output | 1 | Command accepted (always high) |
| cmd_op | input | 3 | Command code: 1 buffer write, 2 load mask, 3 transfer, 4 transfer and read |
| cmd_addr | input | 10 | [2:0] word, [7:3] slot, [9:8] guard (must be zero for a transfer) |
| cmd_data | input | 16 | Write data or mask value |
| cmd_bmask | input | 2 | Per-word byte enables recorded with a buffer write |
| row_rd_blk | input | 5 | Row read slot |
| row_rd_word | input | 3 | Row read word |
| row_rd_data | output | 16 | Row word contents |
| rb_rd_word | input | 3 | Read-buffer read word |
| rb_rd_data | output | 16 | Read-buffer word contents |
| xfer_err | output | 1 | Sticky guard-violation flag |

## Verification
The bench builds the block with its default parameters: 16-bit words, eight words per block, 32 slots and a 10-bit address. With these values the lowest slot (0) and the highest slot (31) can both be reached, and the 16-bit data bus holds exactly one bit for each of the sixteen byte lanes. Mask patterns that protect whole words, single lanes and every upper lane can therefore be driven directly, and each guard bit can be raised on its own.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_BUFWR   = 3'd1,
    OP_LDMASK  = 3'd2,
    OP_XFER    = 3'd3,
    OP_XFER_RD = 3'd4
  } op_e;

  typedef struct packed {
    logic buf_wr;
    logic ld_mask;
    logic xfer;
    logic rd_copy;
    logic bad;
  } dec_t;
endpackage

// File: rtl/xfer_cmd_dec.sv
module xfer_cmd_dec import xfer_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int WIDX_W = 3,
  parameter int BIDX_W = 5
) (
  input  logic              valid,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec,
  output logic [WIDX_W-1:0] widx,
  output logic [BIDX_W-1:0] bidx
);
  localparam int GUARD_LO = WIDX_W + BIDX_W;

  logic is_xfer;
  logic guard_hit;

  assign widx      = addr[WIDX_W-1:0];
  assign bidx      = addr[GUARD_LO-1:WIDX_W];
  assign guard_hit = |addr[ADDR_W-1:GUARD_LO];
  assign is_xfer   = valid && (op == OP_XFER || op == OP_XFER_RD);

  always_comb begin
    dec         = '0;
    dec.buf_wr  = valid && (op == OP_BUFWR);
    dec.ld_mask = valid && (op == OP_LDMASK);
    dec.bad     = is_xfer && guard_hit;
    dec.xfer    = is_xfer && !guard_hit;
    dec.rd_copy = is_xfer && !guard_hit && (op == OP_XFER_RD);
  end
endmodule

// File: rtl/wb_stage1.sv
module wb_stage1 #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 16,
  parameter int LANES  = 2,
  parameter int WIDX_W = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [WIDX_W-1:0]                widx,
  input  logic [WORD_W-1:0]                wdata,
  input  logic [LANES-1:0]                 wbm,
  output logic [WORDS-1:0][WORD_W-1:0]     wb_q,
  output logic [WORDS-1:0][LANES-1:0]      wbm_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_q  <= '0;
      wbm_q <= '0;
    end else if (we) begin
      wb_q[widx]  <= wdata;
      wbm_q[widx] <= wbm;
    end
  end
endmodule

// File: rtl/bmask_reg.sv
module bmask_reg #(
  parameter int MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [MASK_W-1:0] d,
  output logic [MASK_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/row_store.sv
module row_store #(
  parameter int BLOCKS = 32,
  parameter int WORDS  = 8,
  parameter int WORD_W = 16,
  parameter int LANES  = 2,
  parameter int BIDX_W = 5,
  parameter int WIDX_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [BIDX_W-1:0]            blk,
  input  logic [WORDS-1:0][WORD_W-1:0] wdata,
  input  logic [WORDS*LANES-1:0]       bmask,
  input  logic [BIDX_W-1:0]            rd_blk,
  input  logic [WIDX_W-1:0]            rd_word,
  output logic [WORD_W-1:0]            rd_data,
  output logic [WORDS-1:0][WORD_W-1:0] merged,
  output logic [BLOCKS-1:0]            sel
);
  logic [WORDS-1:0][WORD_W-1:0] row_q [BLOCKS];
  logic [WORDS-1:0][WORD_W-1:0] cur;

  for (genvar b = 0; b < BLOCKS; b++) begin : g_sel
    assign sel[b] = we && (blk == BIDX_W'(b));
  end

  assign cur = row_q[blk];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign merged[w][l*8 +: 8] = bmask[w*LANES + l] ? cur[w][l*8 +: 8]
                                                       : wdata[w][l*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < BLOCKS; b++) begin
      if (!rst_n)      row_q[b] <= '0;
      else if (sel[b]) row_q[b] <= merged;
    end
  end

  assign rd_data = row_q[rd_blk][rd_word];
endmodule

// File: rtl/blk_xfer_buf.sv
module blk_xfer_buf import xfer_pkg::*; #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 8,
  parameter int BLOCKS = 32,
  parameter int ADDR_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [2:0]                 cmd_op,
  input  logic [ADDR_W-1:0]          cmd_addr,
  input  logic [WORD_W-1:0]          cmd_data,
  input  logic [WORD_W/8-1:0]        cmd_bmask,
  input  logic [$clog2(BLOCKS)-1:0]  row_rd_blk,
  input  logic [$clog2(WORDS)-1:0]   row_rd_word,
  output logic [WORD_W-1:0]          row_rd_data,
  input  logic [$clog2(WORDS)-1:0]   rb_rd_word,
  output logic [WORD_W-1:0]          rb_rd_data,
  output logic                       xfer_err
);
  localparam int LANES  = WORD_W / 8;
  localparam int MASK_W = WORDS * LANES;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int BIDX_W = $clog2(BLOCKS);

  dec_t                         dec;
  logic [WIDX_W-1:0]            widx;
  logic [BIDX_W-1:0]            bidx;
  logic [WORDS-1:0][WORD_W-1:0] wb1_q, wb2_q, merged, rb_q;
  logic [WORDS-1:0][LANES-1:0]  wbm1_q, wbm2_q;
  logic [MASK_W-1:0]            mask_q;
  logic [BLOCKS-1:0]            blk_sel;
  logic                         err_q;

  assign cmd_ready = 1'b1;

  xfer_cmd_dec #(.ADDR_W(ADDR_W), .WIDX_W(WIDX_W), .BIDX_W(BIDX_W)) i_dec (
    .valid(cmd_valid), .op(cmd_op), .addr(cmd_addr),
    .dec(dec), .widx(widx), .bidx(bidx)
  );

  wb_stage1 #(.WORDS(WORDS), .WORD_W(WORD_W), .LANES(LANES), .WIDX_W(WIDX_W)) i_wb1 (
    .clk(clk), .rst_n(rst_n), .we(dec.buf_wr), .widx(widx),
    .wdata(cmd_data), .wbm(cmd_bmask), .wb_q(wb1_q), .wbm_q(wbm1_q)
  );

  bmask_reg #(.MASK_W(MASK_W)) i_mask (
    .clk(clk), .rst_n(rst_n), .ld(dec.ld_mask),
    .d(cmd_data[MASK_W-1:0]), .q(mask_q)
  );

  row_store #(.BLOCKS(BLOCKS), .WORDS(WORDS), .WORD_W(WORD_W), .LANES(LANES),
              .BIDX_W(BIDX_W), .WIDX_W(WIDX_W)) i_row (
    .clk(clk), .rst_n(rst_n), .we(dec.xfer), .blk(bidx), .wdata(wb1_q),
    .bmask(mask_q), .rd_blk(row_rd_blk), .rd_word(row_rd_word),
    .rd_data(row_rd_data), .merged(merged), .sel(blk_sel)
  );

  // Second stage, read buffer and sticky error flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb2_q  <= '0;
      wbm2_q <= '0;
      rb_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      if (dec.xfer) begin
        wb2_q  <= wb1_q;
        wbm2_q <= wbm1_q;
      end
      if (dec.rd_copy) rb_q <= merged;
      if (dec.bad)     err_q <= 1'b1;
    end
  end

  assign rb_rd_data = rb_q[rb_rd_word];
  assign xfer_err   = err_q;
endmodule

// File: rtl/blk_xfer_buf_chk.sv
module blk_xfer_buf_chk #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 8,
  parameter int BLOCKS = 32,
  parameter int LANES  = 2,
  parameter int MASK_W = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         ld_mask,
  input logic                         xfer,
  input logic                         rd_copy,
  input logic                         bad,
  input logic [WORD_W-1:0]            cmd_data,
  input logic [MASK_W-1:0]            mask_q,
  input logic [BLOCKS-1:0]            blk_sel,
  input logic [WORDS-1:0][WORD_W-1:0] wb1_q,
  input logic [WORDS-1:0][WORD_W-1:0] wb2_q,
  input logic [WORDS-1:0][LANES-1:0]  wbm1_q,
  input logic [WORDS-1:0][LANES-1:0]  wbm2_q,
  input logic [WORDS-1:0][WORD_W-1:0] rb_q,
  input logic                         xfer_err
);
  // R3
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_mask |=> mask_q == $past(cmd_data[MASK_W-1:0]));
  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_mask |=> $stable(mask_q));
  // R4
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(blk_sel));
  // R4
  slot_needs_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |-> blk_sel == '0);
  // R8
  stage2_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (wb2_q == $past(wb1_q)) && (wbm2_q == $past(wbm1_q)));
  // R6
  rb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_copy |=> $stable(rb_q));
  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> xfer_err);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> xfer_err);
endmodule

bind blk_xfer_buf blk_xfer_buf_chk #(
  .WORD_W(WORD_W), .WORDS(WORDS), .BLOCKS(BLOCKS), .LANES(LANES), .MASK_W(MASK_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .ld_mask(dec.ld_mask), .xfer(dec.xfer),
  .rd_copy(dec.rd_copy), .bad(dec.bad), .cmd_data(cmd_data), .mask_q(mask_q),
  .blk_sel(blk_sel), .wb1_q(wb1_q), .wb2_q(wb2_q), .wbm1_q(wbm1_q),
  .wbm2_q(wbm2_q), .rb_q(rb_q), .xfer_err(xfer_err)
);

// File: tb/test_blk_xfer_buf.sv
module test_blk_xfer_buf;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [2:0]  cmd_op;
  logic [9:0]  cmd_addr;
  logic [15:0] cmd_data;
  logic [1:0]  cmd_bmask;
  logic [4:0]  row_rd_blk;
  logic [2:0]  row_rd_word;
  logic [15:0] row_rd_data;
  logic [2:0]  rb_rd_word;
  logic [15:0] rb_rd_data;
  logic        xfer_err;

  always #2 clk = ~clk;

  blk_xfer_buf i_blk_xfer_buf (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_bmask(cmd_bmask),
    .row_rd_blk(row_rd_blk), .row_rd_word(row_rd_word), .row_rd_data(row_rd_data),
    .rb_rd_word(rb_rd_word), .rb_rd_data(rb_rd_data), .xfer_err(xfer_err)
  );

  typedef struct {
    int          kind;   // 0 row word, 1 read-buffer word, 2 error flag
    int          blk;
    int          word;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t       sb[$];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;
  logic [15:0] m_row [32][8];
  logic [15:0] m_wb1 [8];
  logic [15:0] m_rb  [8];
  logic [15:0] m_mask;
  logic        m_err;

  task automatic note(input bit ok, input string req, input logic [15:0] act,
                      input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares them against the read ports
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb.pop_front();
        row_rd_blk  = 5'(it.blk);
        row_rd_word = 3'(it.word);
        rb_rd_word  = 3'(it.word);
        #1;
        case (it.kind)
          0:       act = row_rd_data;
          1:       act = rb_rd_data;
          default: act = {15'd0, xfer_err};
        endcase
        note(act === it.exp, it.req, act, it.exp);
      end
    end
  end

  task automatic exp_row(input int b, input int w, input string req);
    sb.push_back('{0, b, w, m_row[b][w], req});
  endtask
  task automatic exp_rb(input int w, input string req);
    sb.push_back('{1, 0, w, m_rb[w], req});
  endtask
  task automatic exp_err(input string req);
    sb.push_back('{2, 0, 0, {15'd0, m_err}, req});
  endtask
  task automatic exp_blk(input int b, input string req);
    for (int w = 0; w < 8; w++) exp_row(b, w, req);
  endtask
  task automatic exp_rbblk(input string req);
    for (int w = 0; w < 8; w++) exp_rb(w, req);
  endtask
  task automatic drain();
    wait (sb.size() == 0);
    @(negedge clk);
  endtask

  // Driver: issues one command and updates the reference model
  task automatic cmd(input logic [2:0] op, input logic [9:0] addr,
                     input logic [15:0] data, input logic [1:0] bm,
                     input bit valid = 1'b1);
    @(negedge clk);
    cmd_valid = valid; cmd_op = op; cmd_addr = addr; cmd_data = data; cmd_bmask = bm;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    if (valid) begin
      if (op == 3'd1) m_wb1[addr[2:0]] = data;
      else if (op == 3'd2) m_mask = data;
      else if (op == 3'd3 || op == 3'd4) begin
        if (addr[9:8] != 2'b00) m_err = 1'b1;
        else begin
          int b = int'(addr[7:3]);
          for (int w = 0; w < 8; w++) begin
            if (!m_mask[2*w])   m_row[b][w][7:0]  = m_wb1[w][7:0];
            if (!m_mask[2*w+1]) m_row[b][w][15:8] = m_wb1[w][15:8];
          end
          if (op == 3'd4) for (int w = 0; w < 8; w++) m_rb[w] = m_row[b][w];
        end
      end
    end
  endtask

  function automatic logic [9:0] xa(input int blk, input int guard = 0);
    return {2'(guard), 5'(blk), 3'd0};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int b = 0; b < 32; b++) for (int w = 0; w < 8; w++) m_row[b][w] = '0;
    for (int w = 0; w < 8; w++) begin m_wb1[w] = '0; m_rb[w] = '0; end
    m_mask = '0; m_err = 1'b0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0;
    cmd_bmask = '0; row_rd_blk = '0; row_rd_word = '0; rb_rd_word = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    drain();
    #1 note(cmd_ready === 1'b1, "R1 ready", {15'd0, cmd_ready}, 16'd1);
    exp_row(0, 0, "R1 row"); exp_row(31, 7, "R1 row"); exp_row(17, 3, "R1 row");
    exp_rbblk("R1 rb"); exp_err("R1 err");
    drain();
    // R1: first stage and mask are zero: transfer before any write gives zeros
    cmd(3'd1, 10'd0, 16'h0000, 2'b11); // leaves word 0 at zero
    cmd(3'd4, xa(9), 16'h0, 2'b00);
    exp_blk(9, "R1 wb1/mask zero"); exp_rbblk("R1 rb after empty copy");
    drain();

    // R2 / R4: fill the first stage (per-word enables varied, R8) and transfer to slot 5
    for (int w = 0; w < 8; w++) cmd(3'd1, 10'(w), 16'h1100 * 16'(w + 1) + 16'h0021, 2'(w));
    cmd(3'd3, xa(5), 16'h0, 2'b00);
    exp_blk(5, "R4 full write slot 5"); exp_blk(4, "R4 neighbour 4 untouched");
    exp_blk(6, "R4 neighbour 6 untouched"); exp_rbblk("R6 rb unchanged by op 3");
    exp_blk(9, "R8 bmask ignored (slot 9 prior)");
    drain();

    // R2: rewrite a single word, others retained; transfer to slot 0
    cmd(3'd1, 10'd3, 16'hBEEF, 2'b00);
    cmd(3'd3, xa(0), 16'h0, 2'b00);
    exp_blk(0, "R2 single word update / R8");
    drain();

    // R3: protect word 0 both lanes and word 1 lower lane, rewrite slot 5
    for (int w = 0; w < 8; w++) cmd(3'd1, 10'(w), 16'h5A00 + 16'(w * 17), 2'b01);
    cmd(3'd2, 10'd0, 16'h0007, 2'b00);
    cmd(3'd3, xa(5), 16'h0, 2'b00);
    exp_blk(5, "R3 partial mask slot 5");
    drain();

    // R5: all upper lanes protected, transfer-and-read into slot 31
    cmd(3'd2, 10'd0, 16'hAAAA, 2'b00);
    cmd(3'd4, xa(31), 16'h0, 2'b00);
    exp_blk(31, "R5 upper lanes kept slot 31"); exp_rbblk("R5 rb holds written slot");
    drain();

    // R9: mask and first stage reused for slot 30; R6 rb stays
    cmd(3'd3, xa(30), 16'h0, 2'b00);
    exp_blk(30, "R9 reuse wb1 and mask"); exp_rbblk("R6 rb kept after op 3");
    drain();

    // R10: unknown ops and invalid beats do nothing
    cmd(3'd5, xa(30), 16'hFFFF, 2'b11);
    cmd(3'd7, xa(12), 16'h0000, 2'b11);
    cmd(3'd2, 10'd0, 16'hFFFF, 2'b11, 1'b0);   // not valid: mask stays
    cmd(3'd1, 10'd0, 16'h7777, 2'b11, 1'b0);   // not valid: wb1 stays
    cmd(3'd0, xa(12), 16'h1234, 2'b11);
    cmd(3'd4, xa(12), 16'h0, 2'b00);
    exp_blk(12, "R10 state untouched by ignored commands");
    exp_rbblk("R10 rb via op 4"); exp_err("R10 err still low");
    drain();

    // R7: guard bit 8 then bit 9 violations
    cmd(3'd2, 10'd0, 16'h0000, 2'b00);
    cmd(3'd1, 10'd2, 16'hC0DE, 2'b11);
    cmd(3'd4, xa(12, 1), 16'h0, 2'b00);
    exp_blk(12, "R7 guard bit8 slot untouched"); exp_rbblk("R7 rb untouched");
    exp_err("R7 err raised");
    drain();
    cmd(3'd3, xa(0, 2), 16'h0, 2'b00);
    exp_blk(0, "R7 guard bit9 slot 0 untouched");
    cmd(3'd3, xa(1), 16'h0, 2'b00);
    exp_blk(1, "R4 legal transfer after error"); exp_err("R7 err sticky");
    drain();

    finish_run();
  end
endmodule